// File: doc/BRIEF.md
# Multi-row in-memory logic array

This block is a behavioural model of one memory bank that computes while it reads. Every write places the word in a true-data plane and, at the same time, its bitwise complement in a companion plane. Reads are driven by a row mask in which every bit enables one word line. With one bit set the bank behaves as an ordinary memory: the true path returns the stored word and the complement path returns its inverse. With several bits set the true path returns the bitwise AND of all selected words and the complement path returns their bitwise NOR, so a single access combines up to the full row count of operands.

One word sits in each physical row, so bit k of every operand lies in column k and the reduction is purely per column. Both results are registered and appear one clock after the mask is applied. An empty mask behaves like an idle, precharged bit line: both paths read all ones and a flag reports that no row was chosen. A write in the same cycle as a read sees the read return the contents from before that write.

Top module: `mrl_array`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at row `wr_addr` in the true plane and its bitwise complement in the companion plane; a later single-row read of that row returns `wr_data` on `rd_and` and `~wr_data` on `rd_nor`.
- R2: With exactly one bit of `sel_mask` set, `rd_and` equals the word stored in that row and `no_select` is 0.
- R3: With two or more bits of `sel_mask` set, `rd_and` equals the bitwise AND of all selected stored words.
- R4: With one or more bits of `sel_mask` set, `rd_nor` equals the bitwise NOR of all selected stored words (the inverse of their bitwise OR).
- R5: Bit i of `sel_mask` selects row i and only row i; every subset of rows can be chosen in one access.
- R6: With `sel_mask` all zero, `rd_and` and `rd_nor` are all ones and `no_select` is 1.
- R7: When a write and a read that selects the written row happen in the same cycle, the read result uses the data stored before that write; the new data is visible from the following access.
- R8: Results reflect the `sel_mask` present at the rising edge and appear on the outputs right after that edge (one cycle of latency).
- R9: While `rst_n` is low, `rd_and` and `rd_nor` are all ones and `no_select` is 1.
- R10: With `wr_en` low, `wr_addr` and `wr_data` have no effect on stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the result registers |
| sel_mask | input | ROWS | Read word-line mask, bit i selects row i |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(ROWS) | Row written when `wr_en` is high |
| wr_data | input | WORD_W | Word to store |
| rd_and | output | WORD_W | Registered true-path result (stored word or AND) |
| rd_nor | output | WORD_W | Registered complement-path result (inverse word or NOR) |
| no_select | output | 1 | Registered flag, 1 when the mask was empty |

## Verification
The bench builds the bank with 8 rows of 8 bits, which shrinks the mask space to 256 values so every possible row subset, including the empty mask and all single-row masks, is read against several fill patterns. Expected AND and NOR words are folded in the bench from its own copy of the written data. The small row count also makes it cheap to hit the same-cycle write and read of one row and writes with the enable low on every address.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

    localparam int unsigned DEF_WORD_W = 128;
    localparam int unsigned DEF_ROWS   = 128;

    // Which copy of the word a storage plane keeps.
    typedef enum logic {
        PLANE_TRUE = 1'b0,
        PLANE_COMP = 1'b1
    } plane_e;

    localparam int unsigned NUM_PLANES = 2;

endpackage

// File: rtl/mrl_plane.sv
module mrl_plane #(
    parameter int unsigned     WORD_W = mrl_pkg::DEF_WORD_W,
    parameter int unsigned     ROWS   = mrl_pkg::DEF_ROWS,
    parameter mrl_pkg::plane_e PLANE  = mrl_pkg::PLANE_TRUE,
    localparam int unsigned    ADDR_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [ROWS-1:0][WORD_W-1:0]    rows_o
);

    logic [WORD_W-1:0] mem_q [ROWS];
    logic [WORD_W-1:0] store_d;

    // The companion plane keeps the inverted word.
    generate
        if (PLANE == mrl_pkg::PLANE_COMP) begin : g_inv
            assign store_d = ~wr_data;
        end else begin : g_pass
            assign store_d = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < ROWS)) begin
            mem_q[wr_addr] <= store_d;
        end
    end

    generate
        for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
            assign rows_o[r] = mem_q[r];
        end
    endgenerate

endmodule

// File: rtl/mrl_reduce.sv
module mrl_reduce #(
    parameter int unsigned WORD_W = mrl_pkg::DEF_WORD_W,
    parameter int unsigned ROWS   = mrl_pkg::DEF_ROWS
) (
    input  logic [ROWS-1:0][WORD_W-1:0] rows_i,
    input  logic [ROWS-1:0]             mask_i,
    output logic [WORD_W-1:0]           and_o
);

    // Column-wise wired-AND of every enabled row; idle line stays high.
    always_comb begin
        and_o = '1;
        for (int r = 0; r < int'(ROWS); r++) begin
            if (mask_i[r]) begin
                and_o = and_o & rows_i[r];
            end
        end
    end

endmodule

// File: rtl/mrl_array.sv
module mrl_array #(
    parameter int unsigned  WORD_W = mrl_pkg::DEF_WORD_W,
    parameter int unsigned  ROWS   = mrl_pkg::DEF_ROWS,
    localparam int unsigned ADDR_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   sel_mask,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_and,
    output logic [WORD_W-1:0] rd_nor,
    output logic              no_select
);

    typedef struct packed {
        logic [WORD_W-1:0] t_res;
        logic [WORD_W-1:0] c_res;
        logic              nosel;
    } res_t;

    localparam res_t RES_IDLE = '{t_res: '1, c_res: '1, nosel: 1'b1};

    logic [mrl_pkg::NUM_PLANES-1:0][ROWS-1:0][WORD_W-1:0] plane_rows;
    logic [mrl_pkg::NUM_PLANES-1:0][WORD_W-1:0]           plane_res;

    res_t res_d, res_q;

    // One storage plane and one column reducer per polarity.
    generate
        for (genvar p = 0; p < int'(mrl_pkg::NUM_PLANES); p++) begin : g_plane
            localparam mrl_pkg::plane_e KIND =
                (p == 0) ? mrl_pkg::PLANE_TRUE : mrl_pkg::PLANE_COMP;

            mrl_plane #(
                .WORD_W (WORD_W),
                .ROWS   (ROWS),
                .PLANE  (KIND)
            ) plane_i (
                .clk     (clk),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rows_o  (plane_rows[p])
            );

            mrl_reduce #(
                .WORD_W (WORD_W),
                .ROWS   (ROWS)
            ) reduce_i (
                .rows_i (plane_rows[p]),
                .mask_i (sel_mask),
                .and_o  (plane_res[p])
            );
        end
    endgenerate

    // AND of complements is the NOR of the true words.
    always_comb begin
        res_d       = res_q;
        res_d.t_res = plane_res[mrl_pkg::PLANE_TRUE];
        res_d.c_res = plane_res[mrl_pkg::PLANE_COMP];
        res_d.nosel = (sel_mask == '0);
    end

    // Reads sample the planes before this edge's write lands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_and    = res_q.t_res;
    assign rd_nor    = res_q.c_res;
    assign no_select = res_q.nosel;

endmodule

// File: rtl/mrl_array_chk.sv
module mrl_array_chk #(
    parameter int unsigned  WORD_W = mrl_pkg::DEF_WORD_W,
    parameter int unsigned  ROWS   = mrl_pkg::DEF_ROWS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROWS-1:0]   sel_mask,
    input logic [WORD_W-1:0] rd_and,
    input logic [WORD_W-1:0] rd_nor,
    input logic              no_select
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6: empty mask reads idle lines on both paths
    a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(sel_mask) == '0)) |->
            (no_select && (rd_and == '1) && (rd_nor == '1)));

    // R2: one row gives a word and its exact inverse
    a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $onehot($past(sel_mask))) |->
            ((rd_nor == ~rd_and) && !no_select));

    // R4: with any row chosen, no column can be both all-ones and all-zeros
    a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(sel_mask) != '0)) |-> ((rd_and & rd_nor) == '0));

    // R8: flag follows the mask of the previous edge
    a_r8_flag_latency: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (no_select == ($past(sel_mask) == '0)));

endmodule

bind mrl_array mrl_array_chk #(
    .WORD_W (WORD_W),
    .ROWS   (ROWS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_mask  (sel_mask),
    .rd_and    (rd_and),
    .rd_nor    (rd_nor),
    .no_select (no_select)
);

// File: tb/mrl_array_tb_top.sv
`timescale 1ns/1ps
module mrl_array_tb_top;

    localparam int W  = 8;
    localparam int N  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  sel_mask = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_and, rd_nor;
    logic          no_select;

    logic [W-1:0]  model [N];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    mrl_array #(.WORD_W(W), .ROWS(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_mask  (sel_mask),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_and    (rd_and),
        .rd_nor    (rd_nor),
        .no_select (no_select)
    );

    task automatic check(input string req, input logic [W-1:0] act_a, input logic [W-1:0] exp_a,
                         input logic [W-1:0] act_n, input logic [W-1:0] exp_n,
                         input logic act_f, input logic exp_f);
        checks++;
        if (act_a !== exp_a || act_n !== exp_n || act_f !== exp_f) begin
            errors++;
            $display("FAIL %s: and=%h nor=%h flag=%b expected and=%h nor=%h flag=%b",
                     req, act_a, act_n, act_f, exp_a, exp_n, exp_f);
        end
    endtask

    function automatic logic [W-1:0] exp_and(input logic [N-1:0] m);
        logic [W-1:0] a = '1;
        for (int r = 0; r < N; r++) if (m[r]) a &= model[r];
        return a;
    endfunction

    function automatic logic [W-1:0] exp_nor(input logic [N-1:0] m);
        logic [W-1:0] o = '0;
        for (int r = 0; r < N; r++) if (m[r]) o |= model[r];
        return ~o;
    endfunction

    task automatic write_row(input int r, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(r); wr_data = d; sel_mask = '0;
        model[r] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive a mask, sample after the capturing edge.
    task automatic read_and_check(input logic [N-1:0] m, input string req);
        @(negedge clk);
        sel_mask = m;
        @(negedge clk);
        check(req, rd_and, exp_and(m), rd_nor, exp_nor(m), no_select, (m == '0));
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: and=%h nor=%h flag=%b expected completion", rd_and, rd_nor, no_select);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset", rd_and, '1, rd_nor, '1, no_select, 1'b1);
        rst_n = 1'b1;

        for (int pat = 0; pat < 3; pat++) begin
            // R1: fill both planes through writes
            for (int r = 0; r < N; r++)
                write_row(r, W'((r * 37 + 11 + pat * 91) ^ (pat * 8'h5a)));
            // R1, R2: each single row reads word and inverse
            for (int r = 0; r < N; r++)
                read_and_check(N'(1) << r, "R1 R2 single row");
            // R3, R4, R5, R6, R8: every mask subset
            for (int m = 0; m < (1 << N); m++)
                read_and_check(N'(m), "R3 R4 R5 R6 R8 mask sweep");
        end

        // R6: explicit empty mask
        read_and_check('0, "R6 empty mask");

        // R7: write and read of the same row in one cycle
        for (int r = 0; r < N; r++) begin
            logic [W-1:0] oldv, newv;
            logic [N-1:0] m;
            oldv = model[r];
            newv = ~oldv ^ W'(r);
            m    = (N'(1) << r) | (N'(1) << ((r + 3) % N));
            @(negedge clk);
            sel_mask = m; wr_en = 1'b1; wr_addr = AW'(r); wr_data = newv;
            @(negedge clk);
            wr_en = 1'b0;
            check("R7 old data on collision", rd_and, exp_and(m), rd_nor, exp_nor(m), no_select, 1'b0);
            model[r] = newv;
            read_and_check(m, "R7 new data next access");
        end

        // R10: disabled writes leave contents unchanged
        for (int r = 0; r < N; r++) begin
            @(negedge clk);
            sel_mask = '0; wr_en = 1'b0; wr_addr = AW'(r); wr_data = ~model[r];
            @(negedge clk);
            read_and_check(N'(1) << r, "R10 write disabled");
        end
        read_and_check('1, "R10 all rows after disabled writes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule